// File: doc/BRIEF.md
# Floating-Point Dispatch Interlock

This block decides, cycle by cycle, whether an instruction offered to a floating-point unit may enter it, and it models how the unit is occupied afterwards. The arithmetic itself is not present. Each accepted instruction is represented only by its tag. An ordinary operation enters a three-stage shift pipeline. A new one may follow every cycle, so up to three can be in flight together, and each leaves after three cycles.

Two classes of operation instead take the whole unit for their full duration. Long operations, such as divides and reciprocal estimates, carry a requested latency. That latency is forced into the 17..31 cycle window. Status/control operations run for a fixed five cycles. A blocking operation enters only into an empty unit. While it runs, nothing else is admitted. A busy flag reports the blocking period. Every accepted instruction produces exactly one completion pulse carrying its tag, and the pulses come out in issue order.

Top module: `fpq_issue_gate`

## Requirements
- R1: After reset, done_valid and busy are low, and req_ready is high for every class.
- R2: An operation of class code 0 (pipelined) that is accepted in cycle c produces done_valid with its tag in cycle c+3. Class-0 operations may be accepted in consecutive cycles.
- R3: An operation of class code 1 (long) accepted in cycle c completes in cycle c+L. L is req_lat forced into the range 17..31: values below 17 become 17, and values above 31 become 31.
- R4: Class codes 2 and 3 (status/control) are blocking operations that complete exactly 5 cycles after acceptance.
- R5: For a blocking operation accepted in cycle c and completing in cycle c+L, busy is high in cycles c+1 through c+L-1. It is low in cycle c+L.
- R6: From the cycle after a blocking operation is accepted through its completion cycle, req_ready is low for every class. A request held during that time is not accepted and produces no completion. It is accepted in the cycle after the completion.
- R7: A blocking operation is accepted only when no class-0 operation occupies any of the three pipeline stages. Otherwise it stalls until the last one has completed.
- R8: done_valid is high at most once per accepted instruction and never otherwise. Completions come out in issue order, at most one per cycle.
- R9: While no blocking operation is in flight, a class-0 request is accepted even when the pipeline holds other operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A dispatch request is offered this cycle |
| req_class | input | 2 | Operation class: 0 pipelined, 1 long, 2 or 3 status/control |
| req_lat | input | LAT_W | Requested latency for a long operation (forced into 17..31) |
| req_tag | input | TAG_W | Tag of the offered instruction |
| req_ready | output | 1 | The offered request is accepted when req_valid is also high |
| busy | output | 1 | A blocking operation occupies the unit |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completing instruction |

## Verification
Two events can fall in the same cycle. One is the completion of a blocking operation, with its pulse and busy falling. The other is a further request that has been held valid while the unit was blocked. The bench provokes this by issuing a long or status operation and immediately offering the next request, held valid for every cycle. It judges that busy falls exactly in the completion cycle, that req_ready stays low in that cycle, and that acceptance lands in the following cycle. The same collision is provoked at the other boundary, where a blocking request waits on the final pipelined completion. It is judged by the acceptance cycle being exactly one past that completion.

// File: rtl/fpq_pkg.sv
package fpq_pkg;

  typedef enum logic [1:0] {
    OPC_FLOW  = 2'd0,
    OPC_LONG  = 2'd1,
    OPC_CSR_A = 2'd2,
    OPC_CSR_B = 2'd3
  } fpq_opc_e;

  // Every class other than the flowing one holds the unit alone.
  function automatic logic opc_blocks(input logic [1:0] cls);
    return cls != OPC_FLOW;
  endfunction

  // Force a requested latency into [lo, hi].
  function automatic int clamp_lat(input int raw, input int lo, input int hi);
    int v;
    v = raw;
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    return v;
  endfunction

  // Occupancy length of a blocking operation.
  function automatic int block_len(input logic [1:0] cls, input int raw,
                                   input int lo, input int hi, input int ctrl);
    if (cls == OPC_LONG) return clamp_lat(raw, lo, hi);
    return ctrl;
  endfunction

endpackage

// File: rtl/fpq_shift_pipe.sv
module fpq_shift_pipe #(
  parameter int DEPTH = 3,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic             occupied
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] stg_v;
  logic [TAG_W-1:0] stg_tag [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stg_v[0]   <= 1'b0;
            stg_tag[0] <= '0;
          end else begin
            stg_v[0]   <= in_valid;
            stg_tag[0] <= in_tag;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stg_v[i]   <= 1'b0;
            stg_tag[i] <= '0;
          end else begin
            stg_v[i]   <= stg_v[i-1];
            stg_tag[i] <= stg_tag[i-1];
          end
        end

        // Each stage hands its entry on unchanged one cycle later.
        assert_stage_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
          stg_v[i-1] |=> (stg_v[i] && stg_tag[i] == $past(stg_tag[i-1])));
      end
    end
  endgenerate

  assign out_valid = stg_v[LAST];
  assign out_tag   = stg_tag[LAST];
  assign occupied  = |stg_v;

  // A pipeline exit never appears out of nothing.
  assert_exit_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !occupied |=> !out_valid);

endmodule

// File: rtl/fpq_block_timer.sv
module fpq_block_timer #(
  parameter int TAG_W   = 4,
  parameter int LAT_MAX = 31,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_len,
  input  logic [TAG_W-1:0] start_tag,
  output logic             active,
  output logic             done,
  output logic [TAG_W-1:0] done_tag,
  output logic             busy
);

  logic [CNT_W-1:0] remain;
  logic [TAG_W-1:0] held_tag;

  assign done     = active && (remain == '0);
  assign busy     = active && !done;
  assign done_tag = held_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      remain   <= '0;
      held_tag <= '0;
    end else if (start) begin
      active   <= 1'b1;
      remain   <= start_len - CNT_W'(1);
      held_tag <= start_tag;
    end else if (done) begin
      active <= 1'b0;
    end else if (active) begin
      remain <= remain - CNT_W'(1);
    end
  end

  // The gate never launches a second blocking operation over a live one.
  assert_start_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

  // A freshly loaded count stays inside the longest allowed latency.
  assert_len_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (int'(remain) <= LAT_MAX - 1));

  // Busy may only drop in the completion cycle.
  assert_busy_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

// File: rtl/fpq_admit.sv
module fpq_admit
  import fpq_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_class,
  input  logic       blk_active,
  input  logic       pipe_occupied,
  output logic       req_ready,
  output logic       pipe_fire,
  output logic       blk_fire
);

  logic wants_block;

  assign wants_block = opc_blocks(req_class);
  assign req_ready   = !blk_active && (!wants_block || !pipe_occupied);
  assign pipe_fire   = req_valid && req_ready && !wants_block;
  assign blk_fire    = req_valid && req_ready && wants_block;

  assert_fire_exclusive_R8: assert final (!(pipe_fire && blk_fire));

endmodule

// File: rtl/fpq_issue_gate.sv
module fpq_issue_gate
  import fpq_pkg::*;
#(
  parameter int TAG_W      = 4,
  parameter int LAT_W      = 6,
  parameter int PIPE_DEPTH = 3,
  parameter int LAT_MIN    = 17,
  parameter int LAT_MAX    = 31,
  parameter int CTRL_LAT   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_class,
  input  logic [LAT_W-1:0] req_lat,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  output logic             busy,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag
);

  localparam int CNT_W = $clog2(LAT_MAX + 1);

  logic             pipe_fire, blk_fire;
  logic             pipe_occupied, pipe_exit;
  logic [TAG_W-1:0] pipe_exit_tag;
  logic             blk_active, blk_done, blk_busy;
  logic [TAG_W-1:0] blk_done_tag;
  logic [CNT_W-1:0] blk_len;

  assign blk_len = CNT_W'(block_len(req_class, int'(req_lat), LAT_MIN, LAT_MAX, CTRL_LAT));

  fpq_admit u_admit (
    .req_valid     (req_valid),
    .req_class     (req_class),
    .blk_active    (blk_active),
    .pipe_occupied (pipe_occupied),
    .req_ready     (req_ready),
    .pipe_fire     (pipe_fire),
    .blk_fire      (blk_fire)
  );

  fpq_shift_pipe #(.DEPTH(PIPE_DEPTH), .TAG_W(TAG_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pipe_fire),
    .in_tag    (req_tag),
    .out_valid (pipe_exit),
    .out_tag   (pipe_exit_tag),
    .occupied  (pipe_occupied)
  );

  fpq_block_timer #(.TAG_W(TAG_W), .LAT_MAX(LAT_MAX), .CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (blk_fire),
    .start_len (blk_len),
    .start_tag (req_tag),
    .active    (blk_active),
    .done      (blk_done),
    .done_tag  (blk_done_tag),
    .busy      (blk_busy)
  );

  assign busy       = blk_busy;
  assign done_valid = pipe_exit || blk_done;
  assign done_tag   = blk_done ? blk_done_tag : pipe_exit_tag;

  // The two completion sources never collide.
  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pipe_exit && blk_done));

  // A blocking launch sees an empty pipeline.
  assert_block_into_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blk_fire |-> !pipe_occupied);

  // Nothing is admitted while the unit is held.
  assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  // A flowing request enters whenever no blocking operation is live.
  assert_flow_admit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_active && req_class == 2'd0) |-> req_ready);

endmodule

// File: tb/fpq_issue_gate_test.sv
module fpq_issue_gate_test;

  localparam int TAG_W = 4;
  localparam int LAT_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [1:0]       req_class = 2'd0;
  logic [LAT_W-1:0] req_lat = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             req_ready, busy, done_valid;
  logic [TAG_W-1:0] done_tag;

  always #2 clk = ~clk;

  fpq_issue_gate uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_lat(req_lat), .req_tag(req_tag), .req_ready(req_ready), .busy(busy),
    .done_valid(done_valid), .done_tag(done_tag)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  int exp_cyc[$];
  logic [TAG_W-1:0] exp_tag[$];
  int blk_lo = -100, blk_hi = -100, last_flow = -100;
  logic [TAG_W-1:0] next_tag = '0;
  logic s_valid = 1'b0;
  logic [1:0] s_cls = 2'd0;
  int s_lat = 0;
  logic acc = 1'b0;
  int acc_cyc = 0;

  function automatic int want_len(input logic [1:0] c, input int raw);
    if (c == 2'd0) return 3;
    if (c[1]) return 5;
    return (raw > 31) ? 31 : ((raw < 17) ? 17 : raw);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit exp_rdy;
    int len;
    @(negedge clk);
    req_valid = s_valid;
    req_class = s_cls;
    req_lat   = LAT_W'(s_lat);
    req_tag   = next_tag;
    #1;
    if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
      chk("R8 completion expected", int'(done_valid), 1);
      chk("R2/R3/R4 completion tag", int'(done_tag), int'(exp_tag[0]));
      void'(exp_cyc.pop_front());
      void'(exp_tag.pop_front());
    end else begin
      chk("R8 no stray completion", int'(done_valid), 0);
    end
    chk("R5 busy", int'(busy), int'(cyc > blk_lo && cyc < blk_hi));
    acc = 1'b0;
    if (s_valid) begin
      if (cyc > blk_lo && cyc <= blk_hi) begin
        exp_rdy = 1'b0;
        chk("R6 ready held low", int'(req_ready), int'(exp_rdy));
      end else if (s_cls != 2'd0) begin
        exp_rdy = (last_flow + 3 < cyc);
        chk("R7 blocking admit", int'(req_ready), int'(exp_rdy));
      end else begin
        exp_rdy = 1'b1;
        chk("R9 flow admit", int'(req_ready), int'(exp_rdy));
      end
      if (req_ready) begin
        acc = 1'b1;
        acc_cyc = cyc;
        len = want_len(s_cls, s_lat);
        exp_cyc.push_back(cyc + len);
        exp_tag.push_back(next_tag);
        if (s_cls == 2'd0) last_flow = cyc;
        else begin
          blk_lo = cyc;
          blk_hi = cyc + len;
        end
        next_tag = next_tag + 1'b1;
      end
    end
  endtask

  task automatic issue(input logic [1:0] c, input int lat);
    s_valid = 1'b1;
    s_cls = c;
    s_lat = lat;
    for (int k = 0; k < 100; k++) begin
      step();
      if (acc) break;
    end
    s_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    s_valid = 1'b0;
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic drain();
    s_valid = 1'b0;
    while (exp_cyc.size() > 0) step();
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hi_prev;
    int flow_prev;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 done low in reset", int'(done_valid), 0);
    chk("R1 busy low in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    req_class = 2'd1;
    #1;
    chk("R1 ready for blocking after reset", int'(req_ready), 1);
    req_class = 2'd0;
    #1;
    chk("R1 ready for flow after reset", int'(req_ready), 1);
    idle(2);

    // R2/R9: back-to-back flowing operations
    for (int k = 0; k < 8; k++) issue(2'd0, 0);
    drain();
    // R2: flowing operations with gaps
    for (int g = 1; g < 5; g++) begin
      issue(2'd0, 0);
      idle(g);
    end
    drain();

    // R3/R5: every requested latency, below, inside and above the window
    for (int raw = 0; raw < 64; raw++) begin
      issue(2'd1, raw);
      drain();
    end

    // R4: both status/control codes
    issue(2'd2, 0);
    drain();
    issue(2'd3, 40);
    drain();

    // R7: a blocking request waits for the last flowing completion
    issue(2'd0, 0);
    issue(2'd0, 0);
    flow_prev = last_flow;
    issue(2'd1, 20);
    chk("R7 blocking accept after drain", acc_cyc, flow_prev + 4);
    drain();

    // R6: held requests enter right after each blocking completion
    issue(2'd1, 17);
    hi_prev = blk_hi;
    issue(2'd0, 0);
    chk("R6 flow accepted after long", acc_cyc, hi_prev + 1);
    drain();
    issue(2'd2, 0);
    hi_prev = blk_hi;
    issue(2'd1, 25);
    chk("R6 long accepted after status", acc_cyc, hi_prev + 1);
    hi_prev = blk_hi;
    issue(2'd3, 0);
    chk("R6 status accepted after long", acc_cyc, hi_prev + 1);
    drain();

    // R8: mixed traffic, order and single completion per tag
    for (int i = 0; i < 40; i++) begin
      issue(2'(i % 4 == 3 ? 0 : i % 3), 10 + i);
      idle(i % 3);
    end
    drain();
    chk("R8 all completions seen", exp_cyc.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule